// File: doc/BRIEF.md
# HDLC Receive Byte Pool with Fill-Level Interrupts

This block takes the byte stream that an HDLC deframer produces and fills a byte-wide receive pool that the CPU drains. At the start of each frame it separates the address field from the payload. Address bytes always go out on a separate evaluation port. A control bit decides whether they are also stored in the pool, ahead of the payload. In modes without an address field, every byte is stored.

Two interrupt pulses tell the CPU when to read. The pool-full pulse fires when the number of stored bytes reaches a level chosen by a two-bit code. The frame-end pulse fires as soon as the closing byte of a frame has been taken in, whatever the fill level. The input stream has no back-pressure: `in_ready` is always high, and a byte that arrives while the pool is full is lost and recorded in a sticky flag. The read side is a valid/ready stream. A byte leaves on each rising edge where `out_valid` and `out_ready` are both high, and `out_data` holds steady while `out_ready` is low.

Top module: `hdlc_rx_pool`

## Requirements
- R1: The threshold code maps to fill levels as follows: 2'b00 = 32 bytes, 2'b01 = 16, 2'b10 = 4, 2'b11 = 2. `irq_pool` goes high in the second cycle after the write that brings the fill level up to the selected level. A fill level below that level raises no pulse.
- R2: `irq_pool` is high for exactly one cycle. It does not fire again while the fill level stays at or above the threshold. It can fire again only after CPU reads have brought the fill level below the threshold.
- R3: `irq_frame_end` is high for exactly the one cycle that follows the edge accepting a byte with `in_eof` set. This holds whatever the fill level and whatever the threshold.
- R4: When `cfg_addr_mode` is 1, the byte carrying `in_sof` is address byte 0. When `cfg_addr16` is 1, the byte after it is also an address byte. When `cfg_addr16` is 0, only the first byte is address.
- R5: Each address byte shows up on `addr_data` with `addr_valid` high in the cycle after it is accepted. When `cfg_addr_fwd` is 0, the address bytes are not written into the pool.
- R6: When `cfg_addr_fwd` is 1, the address bytes are written into the pool in arrival order, ahead of the payload.
- R7: When `cfg_addr_mode` is 0, every accepted byte is written into the pool and `addr_valid` stays low.
- R8: The pool holds 64 bytes in first-in first-out order. `out_valid` is high whenever the pool is not empty, and a byte is removed on each edge where `out_valid` and `out_ready` are both high.
- R9: A byte accepted while the pool holds 64 bytes is dropped. It sets `overflow`, which stays at 1 until reset.
- R10: After reset, `out_valid`, `irq_pool`, `irq_frame_end`, `addr_valid` and `overflow` are all low. `in_ready` is high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received byte present |
| in_ready | output | 1 | Always 1; the input is never stalled |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| cfg_thresh | input | 2 | Pool threshold code |
| cfg_addr_fwd | input | 1 | 1: store address bytes in the pool |
| cfg_addr16 | input | 1 | 1: two-byte address, 0: one-byte address |
| cfg_addr_mode | input | 1 | 1: frames carry an address field |
| addr_valid | output | 1 | Address byte presented for evaluation |
| addr_data | output | 8 | Address byte |
| out_valid | output | 1 | Pool not empty |
| out_ready | input | 1 | CPU takes the head byte |
| out_data | output | 8 | Head byte of the pool |
| irq_pool | output | 1 | Pool-full interrupt pulse |
| irq_frame_end | output | 1 | Frame-end interrupt pulse |
| overflow | output | 1 | Sticky pool overflow flag |

## Verification
A byte accepted at edge E counts in the fill level right after E. `irq_frame_end` and `addr_valid` are high in the cycle after E. `irq_pool` follows one edge later, in the cycle after E+1. The bench drives its inputs at falling edges, so each check knows exactly which cycle it targets. Directed checks read the interrupts at the first and second falling edges after the last byte is accepted. The scoreboard monitors for pool reads and address events compare at the rising edge that consumes the byte, against expected queues that the driver fills.

// File: rtl/hdlc_rx_pool_pkg.sv
package hdlc_rx_pool_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    POOL_AT_32 = 2'b00,
    POOL_AT_16 = 2'b01,
    POOL_AT_4  = 2'b10,
    POOL_AT_2  = 2'b11
  } pool_thresh_e;

  function automatic int unsigned pool_level(input logic [1:0] code);
    case (pool_thresh_e'(code))
      POOL_AT_32: return 32;
      POOL_AT_16: return 16;
      POOL_AT_4:  return 4;
      default:    return 2;
    endcase
  endfunction
endpackage

// File: rtl/hdlc_addr_sel.sv
module hdlc_addr_sel #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         in_sof,
  input  logic         cfg_addr_mode,
  input  logic         cfg_addr16,
  input  logic         cfg_addr_fwd,
  output logic         wr_req,
  output logic [W-1:0] wr_data,
  output logic         addr_valid,
  output logic [W-1:0] addr_data
);
  // position within frame, saturating at 2 (2 = payload region)
  logic [1:0] pos_q;
  logic [1:0] pos;
  logic       is_addr;

  assign pos     = in_sof ? 2'd0 : pos_q;
  assign is_addr = cfg_addr_mode && ((pos == 2'd0) || (cfg_addr16 && pos == 2'd1));
  assign wr_req  = in_valid && (!is_addr || cfg_addr_fwd);
  assign wr_data = in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q      <= 2'd2;
      addr_valid <= 1'b0;
      addr_data  <= '0;
    end else begin
      if (in_valid) pos_q <= (pos == 2'd2) ? 2'd2 : pos + 2'd1;
      addr_valid <= in_valid && is_addr;
      if (in_valid && is_addr) addr_data <= in_data;
    end
  end

  // R5
  addr_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> $past(in_valid) && $past(cfg_addr_mode));
endmodule

// File: rtl/hdlc_byte_fifo.sv
module hdlc_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_req,
  output logic          rd_valid,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] count,
  output logic          overflow
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, push, pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (count == CW'(DEPTH));
  assign rd_valid = (count != '0);
  assign push     = wr_req && !full;
  assign pop      = rd_req && rd_valid;
  assign rd_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (wr_req && full) overflow <= 1'b1;
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && full && !rd_req) |=> (count == $past(count)) && overflow);
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R8
  last_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_valid && count == CW'(1) && !wr_req) |=> !rd_valid);
endmodule

// File: rtl/hdlc_pool_irq.sv
module hdlc_pool_irq
  import hdlc_rx_pool_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [1:0]    cfg_thresh,
  input  logic          eof_in,
  output logic          irq_pool,
  output logic          irq_frame_end
);
  logic [CW-1:0] level;
  logic          hit;
  logic          armed;

  assign level = CW'(pool_level(cfg_thresh));
  assign hit   = (count >= level);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed         <= 1'b1;
      irq_pool      <= 1'b0;
      irq_frame_end <= 1'b0;
    end else begin
      irq_pool      <= armed && hit;
      irq_frame_end <= eof_in;
      if (armed && hit) armed <= 1'b0;
      else if (!hit)    armed <= 1'b1;
    end
  end

  // R2
  pool_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pool |=> !irq_pool);
endmodule

// File: rtl/hdlc_rx_pool.sv
module hdlc_rx_pool
  import hdlc_rx_pool_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [1:0]        cfg_thresh,
  input  logic              cfg_addr_fwd,
  input  logic              cfg_addr16,
  input  logic              cfg_addr_mode,
  output logic              addr_valid,
  output logic [BYTE_W-1:0] addr_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              irq_pool,
  output logic              irq_frame_end,
  output logic              overflow
);
  logic              wr_req;
  logic [BYTE_W-1:0] wr_data;
  logic [CW-1:0]     fill;

  assign in_ready = 1'b1;

  hdlc_addr_sel #(.W(BYTE_W)) u_sel (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof),
    .cfg_addr_mode(cfg_addr_mode), .cfg_addr16(cfg_addr16), .cfg_addr_fwd(cfg_addr_fwd),
    .wr_req(wr_req), .wr_data(wr_data),
    .addr_valid(addr_valid), .addr_data(addr_data)
  );

  hdlc_byte_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_req(wr_req), .wr_data(wr_data),
    .rd_req(out_ready), .rd_valid(out_valid), .rd_data(out_data),
    .count(fill), .overflow(overflow)
  );

  hdlc_pool_irq #(.CW(CW)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .count(fill), .cfg_thresh(cfg_thresh),
    .eof_in(in_valid && in_eof),
    .irq_pool(irq_pool), .irq_frame_end(irq_frame_end)
  );

  // R3
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eof) |=> irq_frame_end);
endmodule

// File: tb/hdlc_rx_pool_bench.sv
`timescale 1ns/1ps
module hdlc_rx_pool_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic [1:0] cfg_thresh = 2'b11;
  logic       cfg_addr_fwd = 1'b0, cfg_addr16 = 1'b0, cfg_addr_mode = 1'b1;
  logic       out_ready = 1'b0;
  logic       in_ready, addr_valid, out_valid, irq_pool, irq_frame_end, overflow;
  logic [7:0] addr_data, out_data;

  int tests = 0, fails = 0, pool_cnt = 0;
  logic [7:0] exp_q[$];
  logic [7:0] exp_addr_q[$];

  always #10 clk = ~clk;

  hdlc_rx_pool u_hdlc_rx_pool (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .cfg_thresh(cfg_thresh), .cfg_addr_fwd(cfg_addr_fwd), .cfg_addr16(cfg_addr16),
    .cfg_addr_mode(cfg_addr_mode), .addr_valid(addr_valid), .addr_data(addr_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .irq_pool(irq_pool), .irq_frame_end(irq_frame_end), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard monitors: pool reads and address events
  always @(posedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) chk(0, "R8 unexpected read", out_data, -1);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        chk(out_data == e, "R8 read data", out_data, e);
      end
    end
    if (rst_n && addr_valid) begin
      if (exp_addr_q.size() == 0) chk(0, "R7 unexpected address", addr_data, -1);
      else begin
        automatic logic [7:0] a = exp_addr_q.pop_front();
        chk(addr_data == a, "R5 address data", addr_data, a);
      end
    end
    if (rst_n && irq_pool) pool_cnt++;
  end

  task automatic send(input logic [7:0] b, input logic sof, input logic eof,
                      input bit to_pool, input bit to_addr);
    @(negedge clk);
    in_valid = 1'b1; in_data = b; in_sof = sof; in_eof = eof;
    if (to_pool) exp_q.push_back(b);
    if (to_addr) exp_addr_q.push_back(b);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    out_ready = 1'b1;
    do @(negedge clk); while (out_valid);
    out_ready = 1'b0;
  endtask

  task automatic pop1();
    @(negedge clk); out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
  endtask

  // after the last byte: frame-end now, pool pulse next cycle if expected
  task automatic end_checks(input bit pool_exp, input string tag);
    idle();
    chk(irq_frame_end == 1'b1, {"R3 frame end ", tag}, irq_frame_end, 1);
    chk(irq_pool == 1'b0, {"R1 pool early ", tag}, irq_pool, 0);
    @(negedge clk);
    chk(irq_frame_end == 1'b0, {"R3 frame end width ", tag}, irq_frame_end, 0);
    chk(irq_pool == pool_exp, {"R1 pool at level ", tag}, irq_pool, pool_exp);
    @(negedge clk);
    chk(irq_pool == 1'b0, {"R2 pool width ", tag}, irq_pool, 0);
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    report();
  end

  initial begin
    int p0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!out_valid && !irq_pool && !irq_frame_end && !addr_valid && !overflow,
        "R10 reset outputs", {out_valid, irq_pool, irq_frame_end, addr_valid, overflow}, 0);
    chk(in_ready == 1'b1, "R10 in_ready", in_ready, 1);

    // R4/R5: one-byte address stripped, threshold 2 (code 11)
    cfg_thresh = 2'b11; cfg_addr_fwd = 1'b0; cfg_addr16 = 1'b0; cfg_addr_mode = 1'b1;
    send(8'hA0, 1, 0, 0, 1);
    send(8'hD1, 0, 0, 1, 0);
    send(8'hD2, 0, 1, 1, 0);
    end_checks(1'b1, "R4 addr8 strip");
    drain();
    chk(exp_q.size() == 0 && exp_addr_q.size() == 0, "R5 queues drained",
        exp_q.size() + exp_addr_q.size(), 0);

    // R6: two-byte address forwarded, threshold 4 (code 10)
    cfg_thresh = 2'b10; cfg_addr_fwd = 1'b1; cfg_addr16 = 1'b1;
    send(8'hA1, 1, 0, 1, 1);
    send(8'hA2, 0, 0, 1, 1);
    send(8'hD3, 0, 0, 1, 0);
    send(8'hD4, 0, 1, 1, 0);
    end_checks(1'b1, "R6 addr16 fwd");
    drain();

    // R3/R4: two-byte address stripped, one payload byte, below threshold 2
    cfg_thresh = 2'b11; cfg_addr_fwd = 1'b0;
    send(8'hB1, 1, 0, 0, 1);
    send(8'hB2, 0, 0, 0, 1);
    send(8'hB3, 0, 1, 1, 0);
    end_checks(1'b0, "R3 below level");
    drain();

    // R7: no address field, every byte stored, threshold 2
    cfg_addr_mode = 1'b0; cfg_addr_fwd = 1'b0; cfg_addr16 = 1'b0;
    p0 = pool_cnt;
    send(8'hC0, 1, 0, 1, 0);
    send(8'hC1, 0, 0, 1, 0);
    send(8'hC2, 0, 1, 1, 0);
    idle(); repeat (3) @(negedge clk);
    chk(pool_cnt == p0 + 1, "R7 pool once", pool_cnt - p0, 1);
    drain();
    chk(exp_addr_q.size() == 0, "R7 no address events", exp_addr_q.size(), 0);

    // R1/R2: threshold 16 (code 01), no re-fire above, re-arm below
    cfg_thresh = 2'b01;
    p0 = pool_cnt;
    for (int i = 0; i < 15; i++) send(8'(8'h40 + i), i == 0, 0, 1, 0);
    idle(); repeat (3) @(negedge clk);
    chk(pool_cnt == p0, "R1 no pool at 15", pool_cnt - p0, 0);
    send(8'h4F, 0, 0, 1, 0);
    idle(); repeat (3) @(negedge clk);
    chk(pool_cnt == p0 + 1, "R1 pool at 16", pool_cnt - p0, 1);
    send(8'h50, 0, 0, 1, 0);
    send(8'h51, 0, 0, 1, 0);
    idle(); repeat (3) @(negedge clk);
    chk(pool_cnt == p0 + 1, "R2 no refire above", pool_cnt - p0, 1);
    pop1(); pop1(); pop1();
    repeat (3) @(negedge clk);
    chk(pool_cnt == p0 + 1, "R2 no pulse on read", pool_cnt - p0, 1);
    send(8'h52, 0, 1, 1, 0);
    idle(); repeat (3) @(negedge clk);
    chk(pool_cnt == p0 + 2, "R2 refire after rearm", pool_cnt - p0, 2);
    drain();

    // R9: 65 bytes into a 64-byte pool, threshold 32 (code 00)
    cfg_thresh = 2'b00;
    p0 = pool_cnt;
    for (int i = 0; i < 65; i++) send(8'(i), i == 0, i == 64, i < 64, 0);
    idle();
    chk(in_ready == 1'b1, "R10 in_ready while full", in_ready, 1);
    repeat (3) @(negedge clk);
    chk(overflow == 1'b1, "R9 overflow set", overflow, 1);
    chk(pool_cnt == p0 + 1, "R1 pool at 32", pool_cnt - p0, 1);
    drain();
    chk(exp_q.size() == 0, "R9 64 bytes kept", exp_q.size(), 0);
    chk(overflow == 1'b1, "R9 overflow sticky", overflow, 1);
    chk(!out_valid, "R8 empty after drain", out_valid, 0);

    report();
  end
endmodule